// File: doc/BRIEF.md
# Start-Triggered Pattern Counter Sequencer

This block is a small control-plus-datapath sequencer. A three-state controller (Idle, Run, Done) drives a datapath made of a count register and two one-bit flags. In Idle the block waits for a start request. Accepting the request clears the count and the done flag. In Run the count steps up by one every clock, and a tracking flag copies one bit of the count as it stood before that step. The controller leaves Run when a chosen pair of count bits are both set. It then spends one clock in Done, where it raises the done flag, and goes back to Idle.

Every decision uses register contents from before the current clock edge. All register writes in a state take effect together on one edge. The present state is given out as three decoded one-hot lines so that a neighbour can follow the sequence.

States and transitions: Idle (code 00) loops on itself while start is low and goes to Run (code 01) when start is high. Run loops on itself until the exit pattern is seen, then goes to Done (code 11). Done always goes back to Idle. The spare code 10 also goes to Idle and writes no register.

Top module: `asm_seq_ctrl`

## Requirements
- R1: A synchronous active-high reset puts the block in Idle (idle_o=1, run_o=0, done_o=0) and clears count_o, track_o and flag_o to 0.
- R2: In Idle with start_i=0 the block stays in Idle, and count_o, track_o and flag_o keep their values.
- R3: In Idle with start_i=1, after the next edge the block is in Run with count_o=0 and flag_o=0, and track_o keeps its value.
- R4: In Run, count_o rises by exactly 1 on every clock edge. The value of start_i has no effect.
- R5: In Run, after each edge track_o equals bit 1 (LSB = bit 0) of count_o as it was before that edge.
- R6: Run moves to Done only when bits 1 and 2 of the pre-edge count_o are both 1. Otherwise it stays in Run. Starting from 0, the block spends exactly seven clocks in Run, and count_o then reaches 7 with track_o having taken 0,0,1,1,0,0,1.
- R7: In Done, the next edge sets flag_o to 1, keeps count_o and track_o, and returns to Idle whatever start_i is.
- R8: Exactly one of idle_o, run_o and done_o is high in every cycle.
- R9: When start_i is held high through Done, the block re-enters Run right after reaching Idle, with count_o cleared to 0 and flag_o cleared to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start request, sampled in Idle |
| count_o | output | CNT_W (4) | Count register |
| track_o | output | 1 | Tracking flag, copy of a pre-step count bit |
| flag_o | output | 1 | Done flag, set in Done |
| idle_o | output | 1 | Present state is Idle |
| run_o | output | 1 | Present state is Run |
| done_o | output | 1 | Present state is Done |

## Verification
The bench builds the block with its default parameters: a four-bit count, tracking on bit 1, and exit on bits 1 and 2. With these values the exit pattern first appears at the pre-step count of 6. This brings the full seven-cycle Run trace and the Done step inside a handful of clocks, so every value of every cycle can be compared. These settings also make it possible to reach a restart with start held high, a return to Idle while start is held high, and a reset in the middle of Run.

// File: rtl/asm_seq_pkg.sv
package asm_seq_pkg;

    // Codes matter: a neighbour may decode the two-bit state directly.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_RUN   = 2'b01,
        ST_SPARE = 2'b10,
        ST_DONE  = 2'b11
    } seq_state_e;

endpackage

// File: rtl/seq_ctrl.sv
module seq_ctrl
    import asm_seq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    input  logic exit_hit_i,
    output logic idle_o,
    output logic run_o,
    output logic done_o
);

    seq_state_e state_q;
    seq_state_e state_d;

    // State register process
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // Transition decision, based on registered values only
    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE:  state_d = start_i    ? ST_RUN  : ST_IDLE;
            ST_RUN:   state_d = exit_hit_i ? ST_DONE : ST_RUN;
            ST_DONE:  state_d = ST_IDLE;
            ST_SPARE: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Decoded state lines (output process); the spare code drives none
    always_comb begin
        idle_o = 1'b0;
        run_o  = 1'b0;
        done_o = 1'b0;
        unique case (state_q)
            ST_IDLE:  idle_o = 1'b1;
            ST_RUN:   run_o  = 1'b1;
            ST_DONE:  done_o = 1'b1;
            ST_SPARE: ;
            default:  ;
        endcase
    end

endmodule

// File: rtl/seq_datapath.sv
module seq_datapath #(
    parameter int CNT_W     = 4,
    parameter int TRACK_BIT = 1,
    parameter int EXIT_LO   = 1,
    parameter int EXIT_HI   = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             idle_i,
    input  logic             run_i,
    input  logic             done_i,
    output logic [CNT_W-1:0] count_o,
    output logic             track_o,
    output logic             flag_o,
    output logic             exit_hit_o
);

    localparam logic [CNT_W-1:0] EXIT_MASK = CNT_W'((1 << EXIT_LO) | (1 << EXIT_HI));
    localparam logic [CNT_W-1:0] STEP      = CNT_W'(1);

    logic clear_en;
    assign clear_en = idle_i & start_i;

    // Count register: clear on accepted start, step while running
    always_ff @(posedge clk) begin
        if (rst)           count_o <= '0;
        else if (clear_en) count_o <= '0;
        else if (run_i)    count_o <= count_o + STEP;
    end

    // Tracking flag copies one bit of the pre-step count
    always_ff @(posedge clk) begin
        if (rst)        track_o <= 1'b0;
        else if (run_i) track_o <= count_o[TRACK_BIT];
    end

    // Done flag: cleared on start, set in the final state
    always_ff @(posedge clk) begin
        if (rst)           flag_o <= 1'b0;
        else if (clear_en) flag_o <= 1'b0;
        else if (done_i)   flag_o <= 1'b1;
    end

    // Exit status from the registered count
    assign exit_hit_o = ((count_o & EXIT_MASK) == EXIT_MASK);

endmodule

// File: rtl/asm_seq_ctrl.sv
module asm_seq_ctrl #(
    parameter int CNT_W     = 4,
    parameter int TRACK_BIT = 1,
    parameter int EXIT_LO   = 1,
    parameter int EXIT_HI   = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    output logic [CNT_W-1:0] count_o,
    output logic             track_o,
    output logic             flag_o,
    output logic             idle_o,
    output logic             run_o,
    output logic             done_o
);

    logic exit_hit;

    seq_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start_i),
        .exit_hit_i (exit_hit),
        .idle_o     (idle_o),
        .run_o      (run_o),
        .done_o     (done_o)
    );

    seq_datapath #(
        .CNT_W     (CNT_W),
        .TRACK_BIT (TRACK_BIT),
        .EXIT_LO   (EXIT_LO),
        .EXIT_HI   (EXIT_HI)
    ) u_dp (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start_i),
        .idle_i     (idle_o),
        .run_i      (run_o),
        .done_i     (done_o),
        .count_o    (count_o),
        .track_o    (track_o),
        .flag_o     (flag_o),
        .exit_hit_o (exit_hit)
    );

endmodule

// File: rtl/asm_seq_chk.sv
module asm_seq_chk #(
    parameter int CNT_W     = 4,
    parameter int TRACK_BIT = 1,
    parameter int EXIT_LO   = 1,
    parameter int EXIT_HI   = 2
) (
    input logic             clk,
    input logic             rst,
    input logic             start_i,
    input logic [CNT_W-1:0] count_o,
    input logic             track_o,
    input logic             flag_o,
    input logic             idle_o,
    input logic             run_o,
    input logic             done_o
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    AST_RESET_STATE: assert property (@(posedge clk) rst |=> (idle_o && count_o == '0 && !track_o && !flag_o)); // R1
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst) (idle_o && !start_i) |=> (idle_o && $stable(count_o) && $stable(track_o) && $stable(flag_o))); // R2
    AST_START_CLEAR: assert property (@(posedge clk) disable iff (rst) (idle_o && start_i) |=> (run_o && count_o == '0 && !flag_o && $stable(track_o))); // R3
    AST_RUN_STEP: assert property (@(posedge clk) disable iff (rst) run_o |=> (count_o == $past(count_o) + ONE)); // R4
    AST_TRACK_BIT: assert property (@(posedge clk) disable iff (rst) run_o |=> (track_o == $past(count_o[TRACK_BIT]))); // R5
    AST_EXIT_TAKEN: assert property (@(posedge clk) disable iff (rst) (run_o && count_o[EXIT_LO] && count_o[EXIT_HI]) |=> done_o); // R6
    AST_EXIT_HELD: assert property (@(posedge clk) disable iff (rst) (run_o && !(count_o[EXIT_LO] && count_o[EXIT_HI])) |=> run_o); // R6
    AST_DONE_STEP: assert property (@(posedge clk) disable iff (rst) done_o |=> (idle_o && flag_o && $stable(count_o) && $stable(track_o))); // R7
    AST_ONE_STATE: assert property (@(posedge clk) disable iff (rst) $countones({idle_o, run_o, done_o}) == 1); // R8

endmodule

bind asm_seq_ctrl asm_seq_chk #(
    .CNT_W     (CNT_W),
    .TRACK_BIT (TRACK_BIT),
    .EXIT_LO   (EXIT_LO),
    .EXIT_HI   (EXIT_HI)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .start_i (start_i),
    .count_o (count_o),
    .track_o (track_o),
    .flag_o  (flag_o),
    .idle_o  (idle_o),
    .run_o   (run_o),
    .done_o  (done_o)
);

// File: tb/sim_asm_seq_ctrl.sv
module sim_asm_seq_ctrl;

    localparam int CLK_P = 10;
    localparam int ST_I  = 1;   // {done,run,idle} = 001
    localparam int ST_R  = 2;   // 010
    localparam int ST_D  = 4;   // 100

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start_i = 1'b0;
    logic [3:0] count_o;
    logic       track_o, flag_o, idle_o, run_o, done_o;

    int n_chk  = 0;
    int n_bad  = 0;
    bit finished = 1'b0;

    asm_seq_ctrl u0 (
        .clk(clk), .rst(rst), .start_i(start_i),
        .count_o(count_o), .track_o(track_o), .flag_o(flag_o),
        .idle_o(idle_o), .run_o(run_o), .done_o(done_o)
    );

    always #(CLK_P/2) clk = ~clk;

    // Advance one edge, settle away from it
    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    function automatic int st_now();
        return int'({done_o, run_o, idle_o});
    endfunction

    task automatic t_reset();
        rst = 1'b1; start_i = 1'b0;
        tick(); tick();
        chk("R1 state", st_now(), ST_I);
        chk("R1 count", int'(count_o), 0);
        chk("R1 track", int'(track_o), 0);
        chk("R1 flag",  int'(flag_o), 0);
        rst = 1'b0;
    endtask

    task automatic t_idle_hold(input int ea, input int ee, input int ef);
        start_i = 1'b0;
        for (int i = 0; i < 3; i++) begin
            tick();
            chk("R2 state", st_now(), ST_I);
            chk("R2 count", int'(count_o), ea);
            chk("R2 track", int'(track_o), ee);
            chk("R2 flag",  int'(flag_o), ef);
        end
    endtask

    // Seven Run cycles from count 0, then Done, then Idle
    task automatic t_run_body(input bit hold_start);
        int exp_e;
        start_i = hold_start;
        for (int k = 1; k <= 7; k++) begin
            exp_e = ((k - 1) >> 1) & 1;
            tick();
            chk("R4 count", int'(count_o), k);
            chk("R5 track", int'(track_o), exp_e);
            chk("R6 state", st_now(), (k == 7) ? ST_D : ST_R);
            chk("R8 onehot", $countones({idle_o, run_o, done_o}), 1);
        end
        tick();
        chk("R7 flag",  int'(flag_o), 1);
        chk("R7 count", int'(count_o), 7);
        chk("R7 track", int'(track_o), 1);
        chk("R7 state", st_now(), ST_I);
    endtask

    task automatic t_start(input int prev_e);
        start_i = 1'b1;
        tick();
        chk("R3 state", st_now(), ST_R);
        chk("R3 count", int'(count_o), 0);
        chk("R3 flag",  int'(flag_o), 0);
        chk("R3 track", int'(track_o), prev_e);
    endtask

    // Start held high across Done: Idle, then immediately Run again
    task automatic t_restart();
        t_start(1);
        t_run_body(1'b1);
        tick();
        chk("R9 state", st_now(), ST_R);
        chk("R9 count", int'(count_o), 0);
        chk("R9 flag",  int'(flag_o), 0);
        t_run_body(1'b0);
    endtask

    task automatic t_reset_mid();
        start_i = 1'b1;
        tick();
        start_i = 1'b0;
        tick(); tick(); tick();
        chk("R4 mid count", int'(count_o), 3);
        rst = 1'b1;
        tick();
        chk("R1 mid state", st_now(), ST_I);
        chk("R1 mid count", int'(count_o), 0);
        chk("R1 mid track", int'(track_o), 0);
        chk("R1 mid flag",  int'(flag_o), 0);
        rst = 1'b0;
    endtask

    initial begin
        #1;
        t_reset();
        t_idle_hold(0, 0, 0);
        t_start(0);
        t_run_body(1'b0);
        t_idle_hold(7, 1, 1);
        t_restart();
        t_idle_hold(7, 1, 1);
        t_reset_mid();
        t_idle_hold(0, 0, 0);
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #(CLK_P * 5000);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog act=hung exp=complete");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule